// File: doc/BRIEF.md
# Prioritised Vectoring Interrupt Controller

This block gathers interrupt requests for a small CPU core and, at each instruction boundary, chooses the single request that the core should take next. Requests arrive in two ways. Peripheral status flags are gated by their matching enable bits, and several flags may share one interrupt number. Three direct strobes also raise requests: a software trap, an illegal-opcode trap and an external non-maskable request. Every request lands in a sticky pending vector. A bit in that vector is cleared only when its interrupt is taken.

Selection follows a two-level scheme. The software trap comes first and the illegal-opcode trap second, and neither can be masked. The external non-maskable request comes next and is gated only by the core's X mask bit. While it is pending and X is set, the slot yields nothing at all. All remaining sources are gated by the core's I mask bit. They are scanned in the order held in a writable priority table, which starts out as the identity order.

The chosen interrupt is offered on a valid/id/vector interface and held there until the core acknowledges it. The acknowledge produces a one-cycle request to set either X or I, followed by a fixed entry sequence during which nothing new is chosen. A counter tallies the direct raises.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset no entry is offered (`ent_vld`=0), `ent_busy`=0, both mask-set pulses are 0, `raise_cnt`=0, the pending vector is empty and the priority table holds the identity order (slot i holds id i).
- R2: Peripheral source k makes interrupt `PER_MAP[k]` pending only when its flag and its enable are both 1 in the same cycle. A source whose `PER_NO_EN` bit is set needs only its flag. Default map: sources 0 to 3 go to id 3, sources 4 to 7 go to ids 4 to 7, and only source 7 has no enable.
- R3: A selection is made only at a clock edge where `insn_bnd`=1 and no entry is offered or in progress. `ent_vld`, `ent_id` and `ent_vec` then stay constant until `ent_ack` is seen.
- R4: The software trap (id 15) is chosen before everything else whatever the values of I and X. The illegal-opcode trap (id 14) comes next and is also unmaskable.
- R5: When the external non-maskable request (id 13) is pending and neither trap is pending, it is chosen only when X=0. With X=1 no interrupt is chosen, even if maskable sources are pending and I=0.
- R6: With I=1, no source other than ids 13, 14 and 15 is chosen.
- R7: Maskable sources are scanned from table slot 0 upwards, and the first slot whose id is pending wins. A table write (`ord_we`, slot `ord_idx`, value `ord_val`) made while idle changes this order.
- R8: Table writes are ignored while an entry is offered or the entry sequence is running.
- R9: `ent_vec` equals 0xFFC0 plus twice `ent_id`.
- R10: A pending bit clears only when its interrupt is chosen. All other pending bits stay set, including those raised while an entry is held.
- R11: In the cycle after `ent_ack` is accepted, exactly one pulse is high: `set_x_mask` when the id is 13, and `set_i_mask` otherwise. `ent_busy` is then high for ENTRY_CYC (14) cycles, counted from the acknowledge edge.
- R12: `raise_cnt` grows by the number of direct strobes (`swi_req`, `ill_req`, `nmi_req`) that are high in a cycle, and the new value is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_flag | input | NUM_PER | Peripheral status flags |
| per_en | input | NUM_PER | Peripheral enable bits |
| swi_req | input | 1 | Software trap strobe |
| ill_req | input | 1 | Illegal-opcode strobe |
| nmi_req | input | 1 | External non-maskable request strobe |
| ccr_i | input | 1 | Core I mask bit |
| ccr_x | input | 1 | Core X mask bit |
| insn_bnd | input | 1 | Instruction boundary strobe |
| ord_we | input | 1 | Priority table write enable |
| ord_idx | input | log2(NUM_ID) | Priority table slot |
| ord_val | input | log2(NUM_ID) | Interrupt id to store in the slot |
| ent_ack | input | 1 | Core accepts the offered entry |
| ent_vld | output | 1 | Entry offered |
| ent_id | output | log2(NUM_ID) | Offered interrupt number |
| ent_vec | output | 16 | Vector fetch address |
| ent_busy | output | 1 | Entry sequence running |
| set_i_mask | output | 1 | One-cycle request to set I |
| set_x_mask | output | 1 | One-cycle request to set X |
| raise_cnt | output | CNT_W | Count of direct raises |

## Verification
A flag or strobe becomes pending at the edge where it is sampled, so the earliest boundary that can take it is the following edge. The id and vector appear right after that boundary edge. The mask-set pulse appears right after the acknowledge edge. `ent_busy` stays high for 14 samples counted from that edge, and `raise_cnt` moves right after the strobe edge. The bench drives every input 1 ns after a rising edge and reads outputs at that same point, after exactly one edge per step. It counts busy samples one by one, so the length of the entry sequence is checked cycle by cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ENT_IDLE = 2'd0,
        ENT_HOLD = 2'd1,
        ENT_BUSY = 2'd2
    } ent_state_e;

    function automatic logic [15:0] vec_of(input logic [15:0] base, input logic [15:0] id);
        return base + (id << 1);
    endfunction

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int NUM_ID  = 16,
    parameter int NUM_PER = 8,
    parameter logic [NUM_PER-1:0][$clog2(NUM_ID)-1:0] PER_MAP =
        {4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd3, 4'd3, 4'd3},
    parameter logic [NUM_PER-1:0] PER_NO_EN = 8'h80,
    parameter int SWI_ID = 15,
    parameter int ILL_ID = 14,
    parameter int NMI_ID = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PER-1:0] per_flag,
    input  logic [NUM_PER-1:0] per_en,
    input  logic              swi_req,
    input  logic              ill_req,
    input  logic              nmi_req,
    input  logic [NUM_ID-1:0] clr,
    output logic [NUM_ID-1:0] pend
);

    typedef struct packed {
        logic [NUM_ID-1:0] pend;
    } pend_t;

    pend_t             pend_d, pend_q;
    logic [NUM_ID-1:0] set_v;

    always_comb begin
        set_v = '0;
        for (int k = 0; k < NUM_PER; k++) begin
            if (per_flag[k] && (per_en[k] || PER_NO_EN[k])) begin
                set_v[PER_MAP[k]] = 1'b1;
            end
        end
        set_v[SWI_ID] = set_v[SWI_ID] | swi_req;
        set_v[ILL_ID] = set_v[ILL_ID] | ill_req;
        set_v[NMI_ID] = set_v[NMI_ID] | nmi_req;
        pend_d.pend   = (pend_q.pend & ~clr) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q.pend;

    // R10: a pending bit only drops when the selector cleared it
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(pend_q.pend) & ~pend_q.pend) & ~$past(clr)) == '0));

endmodule

// File: rtl/irq_order.sv
module irq_order #(
    parameter int NUM_ID = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [$clog2(NUM_ID)-1:0]              idx,
    input  logic [$clog2(NUM_ID)-1:0]              val,
    input  logic                                   lock,
    output logic [NUM_ID-1:0][$clog2(NUM_ID)-1:0]  tbl
);

    localparam int IDW = $clog2(NUM_ID);

    typedef logic [NUM_ID-1:0][IDW-1:0] tbl_t;

    function automatic tbl_t ident_tbl();
        tbl_t r;
        for (int i = 0; i < NUM_ID; i++) begin
            r[i] = IDW'(i);
        end
        return r;
    endfunction

    localparam tbl_t RESET_TBL = ident_tbl();

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (we && !lock) begin
            tbl_d[idx] = val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= RESET_TBL;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign tbl = tbl_q;

    // R8: writes during an entry leave the table untouched
    p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock) |=> $stable(tbl_q));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_ID = 16,
    parameter int SWI_ID = 15,
    parameter int ILL_ID = 14,
    parameter int NMI_ID = 13
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_ID-1:0]                     pend,
    input  logic [NUM_ID-1:0][$clog2(NUM_ID)-1:0] tbl,
    input  logic                                  ccr_i,
    input  logic                                  ccr_x,
    output logic                                  sel_vld,
    output logic [$clog2(NUM_ID)-1:0]             sel_id
);

    localparam int IDW = $clog2(NUM_ID);

    always_comb begin
        sel_vld = 1'b0;
        sel_id  = '0;
        if (pend[SWI_ID]) begin
            sel_vld = 1'b1;
            sel_id  = IDW'(SWI_ID);
        end else if (pend[ILL_ID]) begin
            sel_vld = 1'b1;
            sel_id  = IDW'(ILL_ID);
        end else if (pend[NMI_ID]) begin
            if (!ccr_x) begin
                sel_vld = 1'b1;
                sel_id  = IDW'(NMI_ID);
            end
        end else if (!ccr_i) begin
            for (int i = 0; i < NUM_ID; i++) begin
                if (!sel_vld && pend[tbl[i]]) begin
                    sel_vld = 1'b1;
                    sel_id  = tbl[i];
                end
            end
        end
    end

    // R5: a blocked non-maskable request stalls every lower source
    p_xgate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[NMI_ID] && ccr_x && !pend[SWI_ID] && !pend[ILL_ID]) |-> !sel_vld);

    // R6: with I set only the three special ids may win
    p_igate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && ccr_i) |-> (sel_id == IDW'(SWI_ID) || sel_id == IDW'(ILL_ID)
                                || sel_id == IDW'(NMI_ID)));

    // R7: the winner is always a pending id
    p_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |-> pend[sel_id]);

endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irq_pkg::*;
#(
    parameter int NUM_ID    = 16,
    parameter int NUM_PER   = 8,
    parameter logic [NUM_PER-1:0][$clog2(NUM_ID)-1:0] PER_MAP =
        {4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd3, 4'd3, 4'd3},
    parameter logic [NUM_PER-1:0] PER_NO_EN = 8'h80,
    parameter int SWI_ID    = 15,
    parameter int ILL_ID    = 14,
    parameter int NMI_ID    = 13,
    parameter logic [15:0] VEC_BASE = 16'hFFC0,
    parameter int ENTRY_CYC = 14,
    parameter int CNT_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PER-1:0]        per_flag,
    input  logic [NUM_PER-1:0]        per_en,
    input  logic                      swi_req,
    input  logic                      ill_req,
    input  logic                      nmi_req,
    input  logic                      ccr_i,
    input  logic                      ccr_x,
    input  logic                      insn_bnd,
    input  logic                      ord_we,
    input  logic [$clog2(NUM_ID)-1:0] ord_idx,
    input  logic [$clog2(NUM_ID)-1:0] ord_val,
    input  logic                      ent_ack,
    output logic                      ent_vld,
    output logic [$clog2(NUM_ID)-1:0] ent_id,
    output logic [15:0]               ent_vec,
    output logic                      ent_busy,
    output logic                      set_i_mask,
    output logic                      set_x_mask,
    output logic [CNT_W-1:0]          raise_cnt
);

    localparam int IDW = $clog2(NUM_ID);
    localparam int CW  = $clog2(ENTRY_CYC + 1);

    typedef struct packed {
        ent_state_e       st;
        logic [IDW-1:0]   id;
        logic [15:0]      vec;
        logic [CW-1:0]    busy_cnt;
        logic             set_i;
        logic             set_x;
        logic [CNT_W-1:0] raises;
    } ctl_t;

    ctl_t                           ctl_d, ctl_q;
    logic [NUM_ID-1:0]              pend;
    logic [NUM_ID-1:0]              clr;
    logic [NUM_ID-1:0][IDW-1:0]     tbl;
    logic                           sel_vld;
    logic [IDW-1:0]                 sel_id;
    logic                           lock;

    assign lock = (ctl_q.st != ENT_IDLE);

    irq_pend #(
        .NUM_ID(NUM_ID), .NUM_PER(NUM_PER), .PER_MAP(PER_MAP), .PER_NO_EN(PER_NO_EN),
        .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .NMI_ID(NMI_ID)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .per_flag(per_flag), .per_en(per_en),
        .swi_req(swi_req), .ill_req(ill_req), .nmi_req(nmi_req),
        .clr(clr), .pend(pend)
    );

    irq_order #(.NUM_ID(NUM_ID)) u_ord (
        .clk(clk), .rst_n(rst_n), .we(ord_we), .idx(ord_idx), .val(ord_val),
        .lock(lock), .tbl(tbl)
    );

    irq_pick #(
        .NUM_ID(NUM_ID), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .NMI_ID(NMI_ID)
    ) u_pick (
        .clk(clk), .rst_n(rst_n), .pend(pend), .tbl(tbl), .ccr_i(ccr_i), .ccr_x(ccr_x),
        .sel_vld(sel_vld), .sel_id(sel_id)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.set_i  = 1'b0;
        ctl_d.set_x  = 1'b0;
        clr          = '0;
        ctl_d.raises = ctl_q.raises + CNT_W'(swi_req) + CNT_W'(ill_req) + CNT_W'(nmi_req);
        case (ctl_q.st)
            ENT_IDLE: begin
                if (insn_bnd && sel_vld) begin
                    ctl_d.st    = ENT_HOLD;
                    ctl_d.id    = sel_id;
                    ctl_d.vec   = vec_of(VEC_BASE, 16'(sel_id));
                    clr[sel_id] = 1'b1;
                end
            end
            ENT_HOLD: begin
                if (ent_ack) begin
                    ctl_d.st       = ENT_BUSY;
                    ctl_d.busy_cnt = CW'(ENTRY_CYC);
                    if (ctl_q.id == IDW'(NMI_ID)) begin
                        ctl_d.set_x = 1'b1;
                    end else begin
                        ctl_d.set_i = 1'b1;
                    end
                end
            end
            ENT_BUSY: begin
                if (ctl_q.busy_cnt <= CW'(1)) begin
                    ctl_d.st       = ENT_IDLE;
                    ctl_d.busy_cnt = '0;
                end else begin
                    ctl_d.busy_cnt = ctl_q.busy_cnt - CW'(1);
                end
            end
            default: ctl_d.st = ENT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ENT_IDLE, id: '0, vec: '0, busy_cnt: '0,
                       set_i: 1'b0, set_x: 1'b0, raises: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ent_vld    = (ctl_q.st == ENT_HOLD);
    assign ent_busy   = (ctl_q.st == ENT_BUSY);
    assign ent_id     = ctl_q.id;
    assign ent_vec    = ctl_q.vec;
    assign set_i_mask = ctl_q.set_i;
    assign set_x_mask = ctl_q.set_x;
    assign raise_cnt  = ctl_q.raises;

    // R3: an offer only starts at a boundary and is held until acknowledged
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ent_vld) |-> $past(insn_bnd));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_vld && !ent_ack) |=> (ent_vld && $stable(ent_id) && $stable(ent_vec)));

    // R9: vector address tracks the offered id
    p_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld |-> (ent_vec == vec_of(VEC_BASE, 16'(ent_id))));

    // R11: entry sequence opens with exactly one mask-set pulse
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ent_busy) |-> (set_i_mask ^ set_x_mask));

    // R12: raise counter follows the direct strobes
    p_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (raise_cnt == $past(raise_cnt)
            + CNT_W'($countones($past({swi_req, ill_req, nmi_req})))));

endmodule

// File: tb/test_irq_vector_ctl.sv
module test_irq_vector_ctl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  per_flag, per_en;
    logic        swi_req, ill_req, nmi_req, ccr_i, ccr_x, insn_bnd;
    logic        ord_we;
    logic [3:0]  ord_idx, ord_val;
    logic        ent_ack;
    logic        ent_vld;
    logic [3:0]  ent_id;
    logic [15:0] ent_vec;
    logic        ent_busy, set_i_mask, set_x_mask;
    logic [15:0] raise_cnt;

    int n_run  = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctl i_irq_vector_ctl (
        .clk(clk), .rst_n(rst_n), .per_flag(per_flag), .per_en(per_en),
        .swi_req(swi_req), .ill_req(ill_req), .nmi_req(nmi_req),
        .ccr_i(ccr_i), .ccr_x(ccr_x), .insn_bnd(insn_bnd),
        .ord_we(ord_we), .ord_idx(ord_idx), .ord_val(ord_val), .ent_ack(ent_ack),
        .ent_vld(ent_vld), .ent_id(ent_id), .ent_vec(ent_vec), .ent_busy(ent_busy),
        .set_i_mask(set_i_mask), .set_x_mask(set_x_mask), .raise_cnt(raise_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic flag(input int k, input bit en);
        per_flag[k] = 1'b1;
        per_en[k]   = en;
        tick();
        per_flag[k] = 1'b0;
        per_en[k]   = 1'b0;
    endtask

    task automatic raise(input bit s, input bit i, input bit n);
        swi_req = s; ill_req = i; nmi_req = n;
        tick();
        swi_req = 1'b0; ill_req = 1'b0; nmi_req = 1'b0;
        exp_cnt += int'(s) + int'(i) + int'(n);
    endtask

    task automatic tbl_write(input int idx, input int val);
        ord_we = 1'b1; ord_idx = 4'(idx); ord_val = 4'(val);
        tick();
        ord_we = 1'b0;
    endtask

    task automatic select_expect(input bit exp_v, input int exp_id, input string req);
        insn_bnd = 1'b1;
        tick();
        insn_bnd = 1'b0;
        chk(ent_vld == exp_v, req, int'(ent_vld), int'(exp_v));
        if (exp_v) begin
            chk(ent_id == 4'(exp_id), req, int'(ent_id), exp_id);
            chk(ent_vec == 16'hFFC0 + 16'(2 * exp_id), "R9", int'(ent_vec), 16'hFFC0 + 2 * exp_id);
        end
    endtask

    task automatic finish_entry(input bit exp_x, input bit wr_busy);
        int n;
        ent_ack = 1'b1;
        tick();
        ent_ack = 1'b0;
        chk(set_x_mask == exp_x, "R11", int'(set_x_mask), int'(exp_x));
        chk(set_i_mask == !exp_x, "R11", int'(set_i_mask), int'(!exp_x));
        n = 0;
        while (ent_busy && n < 100) begin
            n++;
            if (wr_busy && n == 1) begin
                ord_we = 1'b1; ord_idx = 4'd0; ord_val = 4'd3;
            end
            tick();
            ord_we = 1'b0;
            if (n == 1) begin
                chk(!set_i_mask && !set_x_mask, "R11", int'({set_i_mask, set_x_mask}), 0);
            end
        end
        chk(n == 14, "R11", n, 14);
    endtask

    task automatic serve(input int id, input string req);
        select_expect(1'b1, id, req);
        finish_entry(id == 13, 1'b0);
    endtask

    task automatic t_reset();
        chk(!ent_vld && !ent_busy, "R1", int'({ent_vld, ent_busy}), 0);
        chk(!set_i_mask && !set_x_mask, "R1", int'({set_i_mask, set_x_mask}), 0);
        chk(raise_cnt == 16'd0, "R1", int'(raise_cnt), 0);
        select_expect(1'b0, 0, "R1");
    endtask

    task automatic t_periph();
        flag(0, 1'b0);
        select_expect(1'b0, 0, "R2");
        per_en[4] = 1'b1;
        tick();
        per_en[4] = 1'b0;
        select_expect(1'b0, 0, "R2");
        flag(2, 1'b1);
        tick();
        serve(3, "R2");
        select_expect(1'b0, 0, "R10");
        flag(7, 1'b0);
        serve(7, "R2");
    endtask

    task automatic t_hold();
        flag(5, 1'b1);
        insn_bnd = 1'b1;
        tick();
        chk(ent_vld && ent_id == 4'd5, "R3", int'(ent_id), 5);
        for (int c = 0; c < 5; c++) begin
            if (c == 2) swi_req = 1'b1;
            tick();
            swi_req = 1'b0;
            chk(ent_vld && ent_id == 4'd5, "R3", int'(ent_id), 5);
        end
        exp_cnt += 1;
        insn_bnd = 1'b0;
        finish_entry(1'b0, 1'b0);
        serve(15, "R10");
        chk(raise_cnt == 16'(exp_cnt), "R12", int'(raise_cnt), exp_cnt);
    endtask

    task automatic t_prio();
        ccr_i = 1'b1; ccr_x = 1'b1;
        raise(1'b1, 1'b1, 1'b1);
        chk(raise_cnt == 16'(exp_cnt), "R12", int'(raise_cnt), exp_cnt);
        flag(4, 1'b1);
        serve(15, "R4");
        serve(14, "R4");
        select_expect(1'b0, 0, "R5");
        ccr_i = 1'b0;
        select_expect(1'b0, 0, "R5");
        ccr_x = 1'b0;
        serve(13, "R5");
        ccr_i = 1'b1;
        select_expect(1'b0, 0, "R6");
        ccr_i = 1'b0;
        serve(4, "R6");
    endtask

    task automatic t_order();
        flag(4, 1'b1);
        flag(6, 1'b1);
        serve(4, "R7");
        serve(6, "R7");
        tbl_write(0, 6);
        tbl_write(6, 0);
        flag(4, 1'b1);
        flag(6, 1'b1);
        serve(6, "R7");
        serve(4, "R7");
    endtask

    task automatic t_lock();
        flag(5, 1'b1);
        select_expect(1'b1, 5, "R8");
        tbl_write(0, 3);
        finish_entry(1'b0, 1'b0);
        flag(0, 1'b1);
        flag(6, 1'b1);
        serve(6, "R8");
        serve(3, "R8");
        flag(5, 1'b1);
        select_expect(1'b1, 5, "R8");
        finish_entry(1'b0, 1'b1);
        flag(1, 1'b1);
        flag(6, 1'b1);
        serve(6, "R8");
        serve(3, "R8");
    endtask

    initial begin
        rst_n = 1'b0;
        per_flag = '0; per_en = '0;
        swi_req = 1'b0; ill_req = 1'b0; nmi_req = 1'b0;
        ccr_i = 1'b0; ccr_x = 1'b0; insn_bnd = 1'b0;
        ord_we = 1'b0; ord_idx = '0; ord_val = '0; ent_ack = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_periph();
        t_hold();
        t_prio();
        t_order();
        t_lock();
        raise(1'b0, 1'b1, 1'b0);
        chk(raise_cnt == 16'(exp_cnt), "R12", int'(raise_cnt), exp_cnt);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule